// File: doc/BRIEF.md
# FM Operator Phase Increment Generator

This block produces the per-sample phase step for one FM synthesis operator and keeps that operator's 20-bit running phase. The step is built from four inputs: an 11-bit frequency number, a 3-bit octave, a 3-bit detune code and a 4-bit frequency multiplier. The octave and the top frequency bits form a 5-bit key code. A small offset, which depends on the key code, is added to or subtracted from the octave-scaled base frequency. The result is then scaled by the multiplier.

The step is purely combinational and follows its inputs at once. The phase register moves only when a sample strobe arrives. A phase-reset strobe, raised for example when a note starts, clears the phase and forces the step to zero for as long as it is held. The upper ten bits of the phase are meant to address a sine lookup further down the datapath.

Top module: `fm_phase_gen`

## Requirements
- R1: `keycode_o` equals {block_i, n}. Here n is derived from fnum_i[10:7]: codes 0 to 6 give 0, code 7 gives 1, code 8 gives 2, and codes 9 to 15 give 3.
- R2: With detune_i[1:0] = 0, the base frequency is ((fnum_i·2 mod 4096) << block_i) >> 2. This value feeds the multiplier stage without any change.
- R3: With detune_i[1:0] = d ≠ 0, the key code is first limited to 28. Call its upper three bits b and its lower two bits n. Let s = b + 1 + e, where e is 8, 10 or 11 for d = 1, 2 or 3. The offset is T[4·(s mod 2) + n] >> (9 − ⌊s/2⌋), with T = 16, 17, 19, 20, 22, 24, 27, 29 indexed from 0.
- R4: detune_i[2] = 1 subtracts the offset from the base frequency, and detune_i[2] = 0 adds it. The adjusted value is kept modulo 2^17, so a subtraction below zero wraps around.
- R5: `inc_o` = (adjusted × M) >> 1, taken modulo 2^20. M = 1 when mult_i = 0, and M = 2·mult_i otherwise.
- R6: While phase_rst_i = 1, `inc_o` is 0.
- R7: On a rising clock edge with sample_i = 1 and phase_rst_i = 0, `phase_o` becomes (phase_o + inc_o) mod 2^20. With both strobes low, `phase_o` holds its value.
- R8: On a rising clock edge with phase_rst_i = 1, `phase_o` becomes 0, whatever the value of sample_i.
- R9: A synchronous active-high `rst` clears `phase_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fnum_i | input | 11 | Frequency number |
| block_i | input | 3 | Octave |
| detune_i | input | 3 | Detune: bit 2 selects the sign, bits 1:0 select the size |
| mult_i | input | 4 | Frequency multiplier; 0 means one half |
| phase_rst_i | input | 1 | Clears the phase and zeroes the step |
| sample_i | input | 1 | Sample strobe that advances the phase |
| keycode_o | output | 5 | Key code {octave, note} |
| inc_o | output | 20 | Phase step |
| phase_o | output | 20 | Accumulated phase |

## Verification
The bench drives key codes above 28 at the top octave. A design without the key-code limit would look up a detune offset for a nonexistent octave and produce the wrong step. It subtracts an offset from a zero base frequency, which catches a design that saturates or sign-extends where it should wrap modulo 2^17. It also drives the largest multiplier at the largest base frequency, so that a missing 20-bit wrap or a misplaced halving shows up, along with multiplier zero, where a design treating it as 0 or 1 would give a zero or doubled step. Finally, it raises the phase-reset strobe in the same cycle as the sample strobe, which exposes a design that lets the accumulate step win.

// File: rtl/fmpg_pkg.sv
package fmpg_pkg;

    localparam int FNUM_W   = 11;
    localparam int BLK_W    = 3;
    localparam int DT_W     = 3;
    localparam int MUL_W    = 4;
    localparam int PH_W     = 20;
    localparam int KC_W     = BLK_W + 2;
    localparam int OFS_W    = 5;
    localparam int KC_LIMIT = 28;

    // Detune offset: size and direction
    typedef struct packed {
        logic             sub;
        logic [OFS_W-1:0] mag;
    } dt_ofs_t;

    // Note index from the four upper frequency-number bits
    function automatic logic [1:0] note_of(input logic [3:0] hi);
        if (hi <= 4'd6)      return 2'd0;
        else if (hi == 4'd7) return 2'd1;
        else if (hi == 4'd8) return 2'd2;
        else                 return 2'd3;
    endfunction

    // Extra term added to the octave for a given detune size
    function automatic logic [3:0] dt_extra(input logic [1:0] d);
        case (d)
            2'd1:    return 4'd8;
            2'd2:    return 4'd10;
            2'd3:    return 4'd11;
            default: return 4'd0;
        endcase
    endfunction

    // Unshifted detune offset table
    function automatic logic [OFS_W-1:0] dt_seed(input logic [2:0] idx);
        case (idx)
            3'd0:    return 5'd16;
            3'd1:    return 5'd17;
            3'd2:    return 5'd19;
            3'd3:    return 5'd20;
            3'd4:    return 5'd22;
            3'd5:    return 5'd24;
            3'd6:    return 5'd27;
            default: return 5'd29;
        endcase
    endfunction

endpackage

// File: rtl/fmpg_keycode.sv
module fmpg_keycode
    import fmpg_pkg::*;
#(
    parameter int BW = BLK_W
) (
    input  logic [3:0]    fhi_i,
    input  logic [BW-1:0] block_i,
    output logic [BW+1:0] kc_o
);

    always_comb begin
        kc_o = {block_i, note_of(fhi_i)};
    end

endmodule

// File: rtl/fmpg_detune.sv
module fmpg_detune
    import fmpg_pkg::*;
#(
    parameter int KW = KC_W,
    parameter int DW = DT_W
) (
    input  logic [KW-1:0] kc_i,
    input  logic [DW-1:0] dt_i,
    output dt_ofs_t       ofs_o
);

    logic [KW-1:0] kc_lim;
    logic [KW-3:0] oct;
    logic [1:0]    note;
    logic [4:0]    sum;
    logic [3:0]    shamt;
    logic [1:0]    dsize;

    always_comb begin
        dsize  = dt_i[1:0];
        kc_lim = (kc_i > KW'(KC_LIMIT)) ? KW'(KC_LIMIT) : kc_i;
        oct    = kc_lim[KW-1:2];
        note   = kc_lim[1:0];
        sum    = 5'(oct) + 5'd1 + 5'(dt_extra(dsize));
        shamt  = 4'd9 - sum[4:1];
        ofs_o.sub = dt_i[DW-1];
        if (dsize == 2'd0) ofs_o.mag = '0;
        else               ofs_o.mag = dt_seed({sum[0], note}) >> shamt;
    end

    // R3
    always_comb begin
        mag_range_chk: assert (ofs_o.mag <= OFS_W'(29));
    end

endmodule

// File: rtl/fmpg_incr.sv
module fmpg_incr
    import fmpg_pkg::*;
#(
    parameter int FW = FNUM_W,
    parameter int BW = BLK_W,
    parameter int MW = MUL_W,
    parameter int PW = PH_W
) (
    input  logic [FW-1:0] fnum_i,
    input  logic [BW-1:0] block_i,
    input  dt_ofs_t       ofs_i,
    input  logic [MW-1:0] mult_i,
    input  logic          clear_i,
    output logic [PW-1:0] inc_o
);

    localparam int SH_W   = FW + 1 + (2**BW - 1);
    localparam int BASE_W = SH_W - 2;
    localparam int PROD_W = PW + 1;

    logic [SH_W-1:0]   shifted;
    logic [BASE_W-1:0] base;
    logic [BASE_W-1:0] adj;
    logic [MW:0]       mfac;
    logic [PROD_W-1:0] prod;

    always_comb begin
        shifted = SH_W'({fnum_i, 1'b0}) << block_i;
        base    = BASE_W'(shifted >> 2);
        if (ofs_i.sub) adj = base - BASE_W'(ofs_i.mag);
        else           adj = base + BASE_W'(ofs_i.mag);
        mfac    = (mult_i == '0) ? (MW+1)'(1) : {mult_i, 1'b0};
        prod    = PROD_W'(adj * mfac);
        inc_o   = clear_i ? '0 : PW'(prod >> 1);
    end

endmodule

// File: rtl/fmpg_phase_acc.sv
module fmpg_phase_acc
    import fmpg_pkg::*;
#(
    parameter int PW = PH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_i,
    input  logic          prst_i,
    input  logic [PW-1:0] inc_i,
    output logic [PW-1:0] phase_o
);

    always_ff @(posedge clk) begin
        if (rst)           phase_o <= '0;
        else if (prst_i)   phase_o <= '0;
        else if (sample_i) phase_o <= phase_o + inc_i;
    end

    // R7
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_i && !prst_i) |=> phase_o == PW'($past(phase_o) + $past(inc_i)));

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample_i && !prst_i) |=> $stable(phase_o));

    // R8
    prst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        prst_i |=> phase_o == '0);

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> phase_o == '0);

endmodule

// File: rtl/fm_phase_gen.sv
module fm_phase_gen
    import fmpg_pkg::*;
#(
    parameter int FW = FNUM_W,
    parameter int BW = BLK_W,
    parameter int DW = DT_W,
    parameter int MW = MUL_W,
    parameter int PW = PH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] fnum_i,
    input  logic [BW-1:0] block_i,
    input  logic [DW-1:0] detune_i,
    input  logic [MW-1:0] mult_i,
    input  logic          phase_rst_i,
    input  logic          sample_i,
    output logic [BW+1:0] keycode_o,
    output logic [PW-1:0] inc_o,
    output logic [PW-1:0] phase_o
);

    dt_ofs_t ofs;

    fmpg_keycode #(.BW(BW)) u_kc (
        .fhi_i   (fnum_i[FW-1 -: 4]),
        .block_i (block_i),
        .kc_o    (keycode_o)
    );

    fmpg_detune #(.KW(BW+2), .DW(DW)) u_dt (
        .kc_i  (keycode_o),
        .dt_i  (detune_i),
        .ofs_o (ofs)
    );

    fmpg_incr #(.FW(FW), .BW(BW), .MW(MW), .PW(PW)) u_inc (
        .fnum_i  (fnum_i),
        .block_i (block_i),
        .ofs_i   (ofs),
        .mult_i  (mult_i),
        .clear_i (phase_rst_i),
        .inc_o   (inc_o)
    );

    fmpg_phase_acc #(.PW(PW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_i),
        .prst_i   (phase_rst_i),
        .inc_i    (inc_o),
        .phase_o  (phase_o)
    );

    // R6
    always_comb begin
        if (phase_rst_i) inc_zero_chk: assert (inc_o == '0);
    end

    // R1
    always_comb begin
        kc_oct_chk: assert (keycode_o[BW+1:2] == block_i);
    end

endmodule

// File: tb/test_fm_phase_gen.sv
module test_fm_phase_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] fnum;
    logic [2:0]  blk;
    logic [2:0]  dt;
    logic [3:0]  mul;
    logic        prst;
    logic        smp;
    logic [4:0]  kc;
    logic [19:0] inc;
    logic [19:0] ph;

    int checks = 0;
    int fails  = 0;
    int mp     = 0;

    always #2 clk = ~clk;

    fm_phase_gen i_fm_phase_gen (
        .clk(clk), .rst(rst), .fnum_i(fnum), .block_i(blk), .detune_i(dt),
        .mult_i(mul), .phase_rst_i(prst), .sample_i(smp),
        .keycode_o(kc), .inc_o(inc), .phase_o(ph)
    );

    function automatic int ref_kc(int f, int b);
        int hi = f / 128;
        int n;
        if (hi < 7) n = 0;
        else if (hi == 7) n = 1;
        else if (hi == 8) n = 2;
        else n = 3;
        return b * 4 + n;
    endfunction

    function automatic int ref_inc(int f, int b, int d3, int m, bit pr);
        int tbl[8] = '{16, 17, 19, 20, 22, 24, 27, 29};
        int base = (((f * 2) % 4096) * (1 << b)) / 4;
        int off = 0;
        int d = d3 % 4;
        int k, s, e, mf;
        if (d != 0) begin
            k = ref_kc(f, b);
            if (k > 28) k = 28;
            e = (d == 1) ? 8 : ((d == 2) ? 10 : 11);
            s = k / 4 + 1 + e;
            off = tbl[(s % 2) * 4 + k % 4] / (1 << (9 - s / 2));
        end
        base = (d3 >= 4) ? base - off : base + off;
        base = base & 'h1FFFF;
        mf = (m == 0) ? 1 : 2 * m;
        if (pr) return 0;
        return ((base * mf) / 2) & 'hFFFFF;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic setin(int f, int b, int d, int m, bit pr, bit s);
        fnum = 11'(f); blk = 3'(b); dt = 3'(d); mul = 4'(m); prst = pr; smp = s;
    endtask

    task automatic cyc();
        int e;
        #1;
        e = ref_inc(fnum, blk, dt, mul, prst);
        chk("R1 keycode", kc, ref_kc(fnum, blk));
        chk("R2 R3 R4 R5 R6 increment", inc, e);
        chk("R7 R8 R9 phase", ph, mp);
        @(posedge clk);
        if (rst) mp = 0;
        else if (prst) mp = 0;
        else if (smp) mp = (mp + e) & 'hFFFFF;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        rst = 1'b1;
        setin(0, 0, 0, 1, 0, 0);
        @(negedge clk);
        cyc();
        cyc();
        rst = 1'b0;
        chk("R9 reset phase", ph, 0);

        // R1 note boundaries
        setin('h37F, 5, 0, 1, 0, 0); cyc(); chk("R1 code 6", kc, 20);
        setin('h380, 5, 0, 1, 0, 0); cyc(); chk("R1 code 7", kc, 21);
        setin('h400, 5, 0, 1, 0, 0); cyc(); chk("R1 code 8", kc, 22);
        setin('h480, 5, 0, 1, 0, 0); cyc(); chk("R1 code 9", kc, 23);

        // R2 octave shift
        setin('h100, 3, 0, 1, 0, 0); cyc(); chk("R2 base", inc, 'h400);
        for (int b = 0; b < 8; b++) begin
            setin('h123, b, 0, 1, 0, 0); cyc();
        end

        // R3 offset add and key-code limit
        setin('h400, 4, 1, 1, 0, 0); cyc(); chk("R3 offset add", inc, 'h2003);
        setin('h7FF, 7, 3, 1, 0, 0); cyc(); chk("R3 limit", inc, 'h1FFD6);
        for (int d = 0; d < 8; d++) begin
            setin('h6A5, 6, d, 3, 0, 0); cyc();
        end

        // R4 subtract and wrap
        setin('h400, 4, 5, 1, 0, 0); cyc(); chk("R4 subtract", inc, 'h1FFD);
        setin(0, 7, 7, 1, 0, 0);     cyc(); chk("R4 wrap", inc, 'h1FFEA);

        // R5 multiplier half and overflow
        setin('h100, 3, 0, 0, 0, 0);  cyc(); chk("R5 half", inc, 'h200);
        setin('h7FF, 7, 0, 15, 0, 0); cyc(); chk("R5 overflow", inc, 'hDFC40);

        // R7 accumulate with wrap, then hold
        for (int i = 0; i < 12; i++) begin
            setin('h7FF, 7, 3, 15, 0, 1); cyc();
        end
        setin('h7FF, 7, 3, 15, 0, 0); cyc(); cyc();
        chk("R7 hold", ph, mp);

        // R6 step forced to zero under reset strobe
        setin('h7FF, 7, 3, 15, 1, 0); cyc(); chk("R6 inc zero", inc, 0);

        // R8 reset strobe beats sample strobe
        setin('h300, 2, 0, 2, 0, 1); cyc(); cyc();
        setin('h300, 2, 0, 2, 1, 1); cyc(); chk("R8 clear", ph, 0);

        for (int i = 0; i < 500; i++) begin
            setin($urandom % 2048, $urandom % 8, $urandom % 8, $urandom % 16,
                  ($urandom % 8) == 0, $urandom % 2);
            cyc();
        end

        // R9 reset mid-run
        setin('h5A5, 6, 2, 7, 0, 1); cyc(); cyc();
        rst = 1'b1; cyc();
        rst = 1'b0; chk("R9 mid-run", ph, 0);
        cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule